// File: doc/BRIEF.md
# Sort-then-route self-routing switch fabric

This block is an eight-port packet switch fabric for one time slot at a time. Every input port offers a valid flag, a 3-bit destination port number and a payload. All eight inputs are taken together as one slot. The fabric has two parts. A bitonic sorting network places the active packets in ascending destination order and packs them onto the lowest-numbered lanes. A self-routing shuffle-exchange network of 2x2 elements then steers each packet to the output port named by its destination.

Sorting makes the routing network free of internal conflict when the destinations in a slot are distinct. The sort key is the inverted valid flag followed by the destination, so an idle lane compares above any real packet. Idle lanes therefore sink to the bottom of the order and never sit between two packets. Each compare-exchange element moves the whole packet, not just its key.

The sorted slot is registered, and the routed slot is registered again. A slot therefore appears at the outputs two clock edges after it is captured, and a new slot can enter on every cycle. Resolving duplicate destinations, queueing at the outputs and multicast are left to the surrounding logic.

Top module: `sort_route_fabric`

## Requirements
- R1: While `rst_n` is low, and until a captured slot has passed both register stages, `out_valid` and `out_data` are all zero. Asserting reset while a slot is in flight clears that slot.
- R2: A slot present at the inputs at rising edge k appears at the outputs just after rising edge k+2. Slots presented on consecutive edges come out on consecutive edges and do not affect one another.
- R3: The sorted stage holds exactly as many valid entries as the slot captured at the previous edge had valid inputs.
- R4: Sorted lane i holds a valid entry only if every lane below i does too. The valid entries are packed onto lanes 0 upward, because the key {~valid, dest} ranks an idle lane above any destination.
- R5: Among the valid sorted lanes, destinations do not decrease with the lane index. A compare-exchange moves the valid flag, destination and payload together.
- R6: When the valid inputs of a slot carry distinct destinations, `out_valid[p]` is 1 exactly when some valid input named port p (destination field `in_dest[3*i+2:3*i]` of input i).
- R7: When the valid inputs of a slot carry distinct destinations, `out_data[8*p+7:8*p]` equals the payload (`in_data[8*i+7:8*i]`) of the input that named port p. An output port with no packet shows an all-zero payload. Each routing stage uses one destination bit, most significant first, and bit value 0 selects the upper output of a 2x2 element.
- R8: The destination and payload on an input whose valid flag is 0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | PORTS | One valid flag per input port |
| in_dest | input | PORTS*log2(PORTS) | Destination port number per input, input i at bits [3i+2:3i] |
| in_data | input | PORTS*DATA_W | Payload per input, input i at bits [8i+7:8i] |
| out_valid | output | PORTS | Packet present at each output port |
| out_data | output | PORTS*DATA_W | Payload at each output port, zero when idle |

## Verification
Sorted-stage results fall due one rising edge after a slot is captured. The routed outputs fall due two rising edges after capture. The bench drives inputs on falling edges and samples the outputs on the falling edge that follows the second rising edge. In the back-to-back test it keeps the expected values of three slots in flight and compares each one exactly two falling edges after it was driven, so that a one-cycle slip is seen as a mismatch. The bound checker delays its own copies of the input slot's count, destination mask and distinctness flag by one and two registers, so that every comparison lines up with the stage it observes.

// File: rtl/sr_fabric_pkg.sv
package sr_fabric_pkg;

    // Number of compare-exchange columns in a full bitonic sort of 2**lg lanes.
    function automatic int sort_depth(input int lg);
        return (lg * (lg + 1)) / 2;
    endfunction

    // Column index of merge phase p (run length 2**p), sub-step with span 2**q.
    function automatic int merge_column(input int p, input int q);
        return (p * (p - 1)) / 2 + (p - 1 - q);
    endfunction

    // Perfect shuffle: the lane that feeds shuffled position q (rotate right).
    function automatic int shuffle_src(input int q, input int lg);
        return (q >> 1) | ((q & 1) << (lg - 1));
    endfunction

endpackage

// File: rtl/sr_cmp_elem.sv
// Compare-exchange on a whole packet. Key = {~valid, dest}, so an idle lane
// ranks above every real destination. Ties keep their positions.
module sr_cmp_elem #(
    parameter int DEST_W = 3,
    parameter int DATA_W = 8,
    parameter bit ASCEND = 1'b1
) (
    input  logic              a_vld,
    input  logic [DEST_W-1:0] a_dst,
    input  logic [DATA_W-1:0] a_dat,
    input  logic              b_vld,
    input  logic [DEST_W-1:0] b_dst,
    input  logic [DATA_W-1:0] b_dat,
    output logic              up_vld,
    output logic [DEST_W-1:0] up_dst,
    output logic [DATA_W-1:0] up_dat,
    output logic              dn_vld,
    output logic [DEST_W-1:0] dn_dst,
    output logic [DATA_W-1:0] dn_dat
);
    logic [DEST_W:0] key_a;
    logic [DEST_W:0] key_b;
    logic            swap;

    always_comb begin
        key_a = {~a_vld, a_dst};
        key_b = {~b_vld, b_dst};
        swap  = ASCEND ? (key_a > key_b) : (key_a < key_b);
        if (swap) begin
            up_vld = b_vld; up_dst = b_dst; up_dat = b_dat;
            dn_vld = a_vld; dn_dst = a_dst; dn_dat = a_dat;
        end else begin
            up_vld = a_vld; up_dst = a_dst; up_dat = a_dat;
            dn_vld = b_vld; dn_dst = b_dst; dn_dat = b_dat;
        end
    end
endmodule

// File: rtl/sr_bitonic_sorter.sv
// Combinational bitonic sorter built by merging runs of 1, 2, 4, ... lanes.
module sr_bitonic_sorter
    import sr_fabric_pkg::*;
#(
    parameter int N      = 8,
    parameter int DEST_W = 3,
    parameter int DATA_W = 8
) (
    input  logic [N-1:0]             in_vld,
    input  logic [N-1:0][DEST_W-1:0] in_dst,
    input  logic [N-1:0][DATA_W-1:0] in_dat,
    output logic [N-1:0]             out_vld,
    output logic [N-1:0][DEST_W-1:0] out_dst,
    output logic [N-1:0][DATA_W-1:0] out_dat
);
    localparam int LG    = $clog2(N);
    localparam int DEPTH = sort_depth(LG);

    logic              lv [DEPTH+1][N];
    logic [DEST_W-1:0] ld [DEPTH+1][N];
    logic [DATA_W-1:0] lp [DEPTH+1][N];

    for (genvar gi = 0; gi < N; gi++) begin : g_edge
        assign lv[0][gi]   = in_vld[gi];
        assign ld[0][gi]   = in_dst[gi];
        assign lp[0][gi]   = in_dat[gi];
        assign out_vld[gi] = lv[DEPTH][gi];
        assign out_dst[gi] = ld[DEPTH][gi];
        assign out_dat[gi] = lp[DEPTH][gi];
    end

    for (genvar gp = 1; gp <= LG; gp++) begin : g_phase
        for (genvar gr = 0; gr < gp; gr++) begin : g_step
            localparam int Q    = gp - 1 - gr;
            localparam int COL  = merge_column(gp, Q);
            localparam int SPAN = 1 << Q;
            localparam int RUN  = 1 << gp;
            for (genvar gi = 0; gi < N; gi++) begin : g_lane
                if ((gi & SPAN) == 0) begin : g_cmp
                    sr_cmp_elem #(
                        .DEST_W(DEST_W),
                        .DATA_W(DATA_W),
                        .ASCEND((gi & RUN) == 0)
                    ) i_cmp (
                        .a_vld (lv[COL][gi]),
                        .a_dst (ld[COL][gi]),
                        .a_dat (lp[COL][gi]),
                        .b_vld (lv[COL][gi+SPAN]),
                        .b_dst (ld[COL][gi+SPAN]),
                        .b_dat (lp[COL][gi+SPAN]),
                        .up_vld(lv[COL+1][gi]),
                        .up_dst(ld[COL+1][gi]),
                        .up_dat(lp[COL+1][gi]),
                        .dn_vld(lv[COL+1][gi+SPAN]),
                        .dn_dst(ld[COL+1][gi+SPAN]),
                        .dn_dat(lp[COL+1][gi+SPAN])
                    );
                end
            end
        end
    end
endmodule

// File: rtl/sr_route_elem.sv
// 2x2 self-routing element: routing bit 0 -> output 0 (upper), 1 -> output 1.
module sr_route_elem #(
    parameter int DEST_W = 3,
    parameter int DATA_W = 8,
    parameter int SEL    = 0
) (
    input  logic              a_vld,
    input  logic [DEST_W-1:0] a_dst,
    input  logic [DATA_W-1:0] a_dat,
    input  logic              b_vld,
    input  logic [DEST_W-1:0] b_dst,
    input  logic [DATA_W-1:0] b_dat,
    output logic              o0_vld,
    output logic [DEST_W-1:0] o0_dst,
    output logic [DATA_W-1:0] o0_dat,
    output logic              o1_vld,
    output logic [DEST_W-1:0] o1_dst,
    output logic [DATA_W-1:0] o1_dat
);
    always_comb begin
        o0_vld = 1'b0; o0_dst = '0; o0_dat = '0;
        o1_vld = 1'b0; o1_dst = '0; o1_dat = '0;
        if (a_vld && !a_dst[SEL]) begin
            o0_vld = 1'b1; o0_dst = a_dst; o0_dat = a_dat;
        end else if (b_vld && !b_dst[SEL]) begin
            o0_vld = 1'b1; o0_dst = b_dst; o0_dat = b_dat;
        end
        if (a_vld && a_dst[SEL]) begin
            o1_vld = 1'b1; o1_dst = a_dst; o1_dat = a_dat;
        end else if (b_vld && b_dst[SEL]) begin
            o1_vld = 1'b1; o1_dst = b_dst; o1_dat = b_dat;
        end
    end
endmodule

// File: rtl/sr_omega_router.sv
// Shuffle-exchange routing network: each stage shuffles the lanes and then
// steers pairs on one destination bit, most significant bit first.
module sr_omega_router
    import sr_fabric_pkg::*;
#(
    parameter int N      = 8,
    parameter int DEST_W = 3,
    parameter int DATA_W = 8
) (
    input  logic [N-1:0]             in_vld,
    input  logic [N-1:0][DEST_W-1:0] in_dst,
    input  logic [N-1:0][DATA_W-1:0] in_dat,
    output logic [N-1:0]             out_vld,
    output logic [N-1:0][DEST_W-1:0] out_dst,
    output logic [N-1:0][DATA_W-1:0] out_dat
);
    localparam int LG = $clog2(N);

    logic              rv [LG+1][N];
    logic [DEST_W-1:0] rd [LG+1][N];
    logic [DATA_W-1:0] rp [LG+1][N];

    for (genvar gi = 0; gi < N; gi++) begin : g_edge
        assign rv[0][gi]   = in_vld[gi];
        assign rd[0][gi]   = in_dst[gi];
        assign rp[0][gi]   = in_dat[gi];
        assign out_vld[gi] = rv[LG][gi];
        assign out_dst[gi] = rd[LG][gi];
        assign out_dat[gi] = rp[LG][gi];
    end

    for (genvar gs = 0; gs < LG; gs++) begin : g_stage
        localparam int BIT = LG - 1 - gs;
        for (genvar ge = 0; ge < N / 2; ge++) begin : g_elem
            localparam int UP = shuffle_src(2 * ge, LG);
            localparam int LO = shuffle_src(2 * ge + 1, LG);
            sr_route_elem #(
                .DEST_W(DEST_W),
                .DATA_W(DATA_W),
                .SEL   (BIT)
            ) i_elem (
                .a_vld (rv[gs][UP]),
                .a_dst (rd[gs][UP]),
                .a_dat (rp[gs][UP]),
                .b_vld (rv[gs][LO]),
                .b_dst (rd[gs][LO]),
                .b_dat (rp[gs][LO]),
                .o0_vld(rv[gs+1][2*ge]),
                .o0_dst(rd[gs+1][2*ge]),
                .o0_dat(rp[gs+1][2*ge]),
                .o1_vld(rv[gs+1][2*ge+1]),
                .o1_dst(rd[gs+1][2*ge+1]),
                .o1_dat(rp[gs+1][2*ge+1])
            );
        end
    end
endmodule

// File: rtl/sort_route_fabric.sv
// Sort-then-route fabric: sorter -> register -> router -> register.
module sort_route_fabric #(
    parameter int PORTS  = 8,
    parameter int DATA_W = 8,
    localparam int DEST_W = $clog2(PORTS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [PORTS-1:0]           in_valid,
    input  logic [PORTS*DEST_W-1:0]    in_dest,
    input  logic [PORTS*DATA_W-1:0]    in_data,
    output logic [PORTS-1:0]           out_valid,
    output logic [PORTS*DATA_W-1:0]    out_data
);
    typedef struct packed {
        logic [PORTS-1:0]             s_vld;
        logic [PORTS-1:0][DEST_W-1:0] s_dst;
        logic [PORTS-1:0][DATA_W-1:0] s_dat;
        logic [PORTS-1:0]             o_vld;
        logic [PORTS-1:0][DEST_W-1:0] o_dst;
        logic [PORTS-1:0][DATA_W-1:0] o_dat;
    } pipe_t;

    pipe_t pipe_d;
    pipe_t pipe_q;

    logic [PORTS-1:0][DEST_W-1:0] in_dst_w;
    logic [PORTS-1:0][DATA_W-1:0] in_dat_w;
    logic [PORTS-1:0]             srt_vld;
    logic [PORTS-1:0][DEST_W-1:0] srt_dst;
    logic [PORTS-1:0][DATA_W-1:0] srt_dat;
    logic [PORTS-1:0]             rt_vld;
    logic [PORTS-1:0][DEST_W-1:0] rt_dst;
    logic [PORTS-1:0][DATA_W-1:0] rt_dat;

    assign in_dst_w = in_dest;
    assign in_dat_w = in_data;

    sr_bitonic_sorter #(
        .N(PORTS), .DEST_W(DEST_W), .DATA_W(DATA_W)
    ) i_sorter (
        .in_vld (in_valid),
        .in_dst (in_dst_w),
        .in_dat (in_dat_w),
        .out_vld(srt_vld),
        .out_dst(srt_dst),
        .out_dat(srt_dat)
    );

    sr_omega_router #(
        .N(PORTS), .DEST_W(DEST_W), .DATA_W(DATA_W)
    ) i_router (
        .in_vld (pipe_q.s_vld),
        .in_dst (pipe_q.s_dst),
        .in_dat (pipe_q.s_dat),
        .out_vld(rt_vld),
        .out_dst(rt_dst),
        .out_dat(rt_dat)
    );

    always_comb begin
        pipe_d       = pipe_q;
        pipe_d.s_vld = srt_vld;
        pipe_d.s_dst = srt_dst;
        pipe_d.s_dat = srt_dat;
        pipe_d.o_vld = rt_vld;
        pipe_d.o_dst = rt_dst;
        pipe_d.o_dat = rt_dat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.o_vld;
    assign out_data  = pipe_q.o_dat;
endmodule

// File: rtl/sr_fabric_chk.sv
module sr_fabric_chk #(
    parameter int PORTS  = 8,
    parameter int DEST_W = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [PORTS-1:0]        in_valid,
    input logic [PORTS*DEST_W-1:0] in_dest,
    input logic [PORTS-1:0]        sort_vld,
    input logic [PORTS*DEST_W-1:0] sort_dst,
    input logic [PORTS-1:0]        out_valid,
    input logic [PORTS*DEST_W-1:0] out_dst
);
    localparam int CW = $clog2(PORTS + 1);

    logic [1:0]       warm;
    logic [CW-1:0]    cur_cnt, cnt1, cnt2;
    logic [PORTS-1:0] cur_mask, mask1, mask2;
    logic             cur_dist, dist1, dist2;
    logic             sorted_ok, dst_ok;
    logic [PORTS-1:0] conc;

    always_comb begin
        cur_cnt  = '0;
        cur_mask = '0;
        for (int i = 0; i < PORTS; i++) begin
            if (in_valid[i]) begin
                cur_cnt = cur_cnt + CW'(1);
                cur_mask[in_dest[i*DEST_W +: DEST_W]] = 1'b1;
            end
        end
        cur_dist = ($countones(cur_mask) == int'(cur_cnt));
        sorted_ok = 1'b1;
        for (int i = 0; i < PORTS - 1; i++) begin
            if (sort_vld[i] && sort_vld[i+1] &&
                (sort_dst[i*DEST_W +: DEST_W] > sort_dst[(i+1)*DEST_W +: DEST_W]))
                sorted_ok = 1'b0;
        end
        dst_ok = 1'b1;
        for (int p = 0; p < PORTS; p++) begin
            if (out_valid[p] && (out_dst[p*DEST_W +: DEST_W] != DEST_W'(p)))
                dst_ok = 1'b0;
        end
        conc = sort_vld & (sort_vld + PORTS'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm  <= 2'd0;
            cnt1  <= '0; cnt2  <= '0;
            mask1 <= '0; mask2 <= '0;
            dist1 <= 1'b0; dist2 <= 1'b0;
        end else begin
            if (warm != 2'd2) warm <= warm + 2'd1;
            cnt1  <= cur_cnt;  cnt2  <= cnt1;
            mask1 <= cur_mask; mask2 <= mask1;
            dist1 <= cur_dist; dist2 <= dist1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 2'd2) |-> (out_valid == '0));

    // R3
    sort_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 2'd0) |-> ($countones(sort_vld) == int'(cnt1)));

    // R4
    sort_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conc == '0);

    // R5
    sort_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sorted_ok);

    // R6
    delivery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && dist2) |-> (out_valid == mask2));

    // R7
    port_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_ok);
endmodule

bind sort_route_fabric sr_fabric_chk #(
    .PORTS (PORTS),
    .DEST_W(DEST_W)
) u_fabric_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_dest  (in_dest),
    .sort_vld (pipe_q.s_vld),
    .sort_dst (pipe_q.s_dst),
    .out_valid(out_valid),
    .out_dst  (pipe_q.o_dst)
);

// File: tb/test_sort_route_fabric.sv
module test_sort_route_fabric;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  in_valid;
    logic [23:0] in_dest;
    logic [63:0] in_data;
    logic [7:0]  out_valid;
    logic [63:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sort_route_fabric #(.PORTS(8), .DATA_W(8)) i_sort_route_fabric (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    // Destinations follow (i*a + b) mod 8 with a odd: a permutation.
    // Payload of input i is {base, i}. garb puts junk on idle inputs.
    task automatic build(input logic [7:0] m, input int a, input int b,
                         input logic [4:0] base, input bit garb,
                         output logic [7:0] v, output logic [23:0] d,
                         output logic [63:0] p, output logic [7:0] ev,
                         output logic [63:0] ed);
        v = m; d = '0; p = '0; ev = '0; ed = '0;
        for (int i = 0; i < 8; i++) begin
            int t;
            t = (i * a + b) % 8;
            if (garb && !m[i]) begin
                d[i*3 +: 3] = 3'd0;
                p[i*8 +: 8] = 8'hA5;
            end else begin
                d[i*3 +: 3] = 3'(t);
                p[i*8 +: 8] = {base, 3'(i)};
            end
            if (m[i]) begin
                ev[t]       = 1'b1;
                ed[t*8 +: 8] = {base, 3'(i)};
            end
        end
    endtask

    task automatic drive(input logic [7:0] v, input logic [23:0] d, input logic [63:0] p);
        in_valid = v; in_dest = d; in_data = p;
    endtask

    task automatic expect_out(input string tag, input logic [7:0] ev, input logic [63:0] ed);
        checks++;
        if (out_valid !== ev) begin
            errors++;
            $display("FAIL %s out_valid actual %b expected %b", tag, out_valid, ev);
        end
        checks++;
        if (out_data !== ed) begin
            errors++;
            $display("FAIL %s out_data actual %h expected %h", tag, out_data, ed);
        end
    endtask

    task automatic run_slot(input string tag, input logic [7:0] m, input int a,
                            input int b, input logic [4:0] base, input bit garb);
        logic [7:0] v, ev; logic [23:0] d; logic [63:0] p, ed;
        build(m, a, b, base, garb, v, d, p, ev, ed);
        @(negedge clk); drive(v, d, p);
        @(negedge clk);
        @(negedge clk);
        expect_out(tag, ev, ed);
    endtask

    initial begin
        logic [7:0] v0, v1, v2, e0, e1, e2;
        logic [23:0] d0, d1, d2;
        logic [63:0] p0, p1, p2, f0, f1, f2;
        int n;
        rst_n = 1'b0;
        drive('0, '0, '0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        expect_out("R1 held in reset", '0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 first cycle after release", '0, '0);

        // R2: latency of a single slot, not early after one edge
        build(8'hFF, 3, 1, 5'd3, 1'b0, v0, d0, p0, e0, f0);
        drive(v0, d0, p0);
        @(negedge clk);
        expect_out("R2 one edge after capture", '0, '0);
        drive('0, '0, '0);
        @(negedge clk);
        expect_out("R2 two edges after capture", e0, f0);

        // R2: three slots back to back
        build(8'b1010_0110, 5, 2, 5'd7, 1'b0, v0, d0, p0, e0, f0);
        build(8'b0001_1111, 1, 3, 5'd9, 1'b0, v1, d1, p1, e1, f1);
        build(8'b1100_0001, 7, 6, 5'd11, 1'b1, v2, d2, p2, e2, f2);
        @(negedge clk); drive(v0, d0, p0);
        @(negedge clk); drive(v1, d1, p1);
        @(negedge clk); expect_out("R2 pipelined slot 0", e0, f0); drive(v2, d2, p2);
        @(negedge clk); expect_out("R2 pipelined slot 1", e1, f1); drive('0, '0, '0);
        @(negedge clk); expect_out("R2 pipelined slot 2", e2, f2);

        // R3 R4 R5 R6 R7: every active subset under 32 destination permutations
        n = 0;
        for (int a = 1; a < 8; a += 2) begin
            for (int b = 0; b < 8; b++) begin
                for (int m = 0; m < 256; m++) begin
                    run_slot("R3 R4 R5 R6 R7 delivery sweep", 8'(m), a, b, 5'(n), 1'b0);
                    n++;
                end
            end
        end

        // R8: idle inputs carry clashing destinations and junk payloads
        for (int m = 0; m < 256; m++) begin
            run_slot("R8 idle inputs ignored", 8'(m), 5, 4, 5'(m), 1'b1);
        end

        // R1: reset while a slot is in flight
        build(8'hFF, 1, 0, 5'd21, 1'b0, v0, d0, p0, e0, f0);
        @(negedge clk); drive(v0, d0, p0);
        @(negedge clk); drive('0, '0, '0);
        rst_n = 1'b0;
        #1;
        expect_out("R1 reset mid-flight", '0, '0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 slot flushed by reset", '0, '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule